// File: doc/BRIEF.md
# Tagged Integer Add/Subtract Unit

This block adds or subtracts two 32-bit integers and registers the result together with four condition flags: negative, zero, signed overflow and carry/borrow. The second operand is either a full register value or a 13-bit immediate that is sign-extended, so its range runs from -4096 to +4095. The flags are written only when the caller asks for it. This gives each operation a form that sets the flags and a form that leaves them alone.

A tagged mode supports language runtimes that keep a two-bit type tag in the low bits of each integer word. In that mode the overflow flag is also raised whenever either operand carries a nonzero tag. A trapping form of the tagged operation does not commit its outcome when overflow occurs. Instead it raises a one-cycle trap request and leaves both the result and the flags unchanged. Every output is registered, so an operation presented with `op_valid` in one cycle is visible after the next rising clock edge.

Top module: `tagged_addsub_unit`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `result` is zero, all four flags are zero and `trap_req` is low.
- R2: With `op_valid` high and `sub_sel` low, `result` shows (opa + operand2) mod 2^32 after the next rising clock edge.
- R3: With `op_valid` high and `sub_sel` high, `result` shows (opa - operand2) mod 2^32 after the next rising clock edge.
- R4: Operand2 is `opb` when `use_imm` is 0. When `use_imm` is 1, operand2 is `imm`, a 13-bit two's-complement value sign-extended to 32 bits (13'h1000 is -4096 and 13'h0FFF is +4095).
- R5: When the flags update, `flag_n` equals bit 31 of the new result, and `flag_z` is 1 exactly when all 32 bits of the new result are zero.
- R6: When the flags update, `flag_c` holds the carry out of bit 31 for an add. For a subtract it holds the borrow, which is 1 exactly when opa < operand2 taken as unsigned values.
- R7: When the flags update outside tagged mode, `flag_v` is 1 exactly when the two's-complement result overflows. For an add this means the operands share a sign that differs from the result's sign. For a subtract it means the operands differ in sign and the result's sign differs from opa's.
- R8: In tagged mode (`tag_mode`=1), `flag_v` is the OR of the R7 overflow and the condition that bits 1:0 of opa or of operand2 are nonzero.
- R9: When `flags_en` is 0, the operation still updates `result`, but all four flags keep their previous values.
- R10: When `tag_mode`=1, `trap_mode`=1 and the overflow of R8 is 1, `trap_req` is high for the one cycle after the edge, and neither `result` nor the flags change.
- R11: In a cycle with `op_valid` low, `result` and the flags keep their values and `trap_req` is low after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| sub_sel | input | 1 | 0 selects add, 1 selects subtract |
| tag_mode | input | 1 | Treat bits 1:0 of each operand as a type tag |
| trap_mode | input | 1 | In tag mode, trap on overflow instead of committing |
| flags_en | input | 1 | Write the condition flags for this operation |
| use_imm | input | 1 | Take operand2 from the immediate |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand when `use_imm` is 0 |
| imm | input | 13 | Signed immediate for operand2 |
| result | output | 32 | Registered result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag, including tag overflow |
| flag_c | output | 1 | Carry on add, borrow on subtract |
| trap_req | output | 1 | One-cycle trap request |

## Verification
Random operands, operation kinds and mode bits from a fixed seed are mixed with directed values that sit on the arithmetic edges. These edges are the largest positive plus a small value, zero minus a nonzero value, equal operands and both immediate extremes. Sign-boundary operands separate signed overflow from unsigned carry. Equal-operand subtracts separate the zero flag from the borrow. Operands whose tags are nonzero but whose sum does not overflow show that the tag check alone sets overflow. The same operands with trapping enabled must hold the result while raising the trap. Operations with the flag write disabled, and idle cycles, show that state is kept.

// File: rtl/tagged_addsub_unit.sv
`timescale 1ns/1ps
module tagged_addsub_unit #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 13,
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic             sub_sel,
  input  logic             tag_mode,
  input  logic             trap_mode,
  input  logic             flags_en,
  input  logic             use_imm,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [IMM_W-1:0] imm,
  output logic [WIDTH-1:0] result,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_v,
  output logic             flag_c,
  output logic             trap_req
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_ext;
  logic [WIDTH-1:0] b_in;
  logic [WIDTH:0]   sum;
  logic [WIDTH-1:0] res_next;
  logic             sgn_ovf;
  logic             tag_bad;
  logic             v_next;
  logic             c_next;
  logic             trap_now;
  logic             commit;

  assign b_ext    = use_imm ? {{(WIDTH-IMM_W){imm[IMM_W-1]}}, imm} : opb;
  assign b_in     = sub_sel ? ~b_ext : b_ext;
  assign sum      = {1'b0, opa} + {1'b0, b_in} + {{WIDTH{1'b0}}, sub_sel};
  assign res_next = sum[MSB:0];
  assign sgn_ovf  = (opa[MSB] == b_in[MSB]) && (res_next[MSB] != opa[MSB]);
  assign tag_bad  = tag_mode && ((|opa[TAG_W-1:0]) || (|b_ext[TAG_W-1:0]));
  assign v_next   = sgn_ovf || tag_bad;
  assign c_next   = sub_sel ? ~sum[WIDTH] : sum[WIDTH];
  assign trap_now = op_valid && tag_mode && trap_mode && v_next;
  assign commit   = op_valid && !trap_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result   <= '0;
      flag_n   <= 1'b0;
      flag_z   <= 1'b0;
      flag_v   <= 1'b0;
      flag_c   <= 1'b0;
      trap_req <= 1'b0;
    end else begin
      trap_req <= trap_now;
      if (commit) begin
        result <= res_next;
        if (flags_en) begin
          flag_n <= res_next[MSB];
          flag_z <= ~|res_next;
          flag_v <= v_next;
          flag_c <= c_next;
        end
      end
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (result == '0) && !trap_req && !flag_n && !flag_z && !flag_v && !flag_c);

  a_r5_nz_track: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && flags_en && !trap_now) |=> (flag_n == result[MSB]) && (flag_z == (result == '0)));

  a_r8_tag_sets_v: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && tag_mode && flags_en && (|opa[TAG_W-1:0])) |=> (flag_v || trap_req));

  a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && flags_en) |=> $stable({flag_n, flag_z, flag_v, flag_c}));

  a_r10_trap_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $stable(result) && $stable({flag_n, flag_z, flag_v, flag_c}));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !trap_req && $stable(result));
endmodule

// File: tb/tagged_addsub_unit_tb.sv
`timescale 1ns/1ps
module tagged_addsub_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0, sub_sel = 1'b0, tag_mode = 1'b0, trap_mode = 1'b0;
  logic        flags_en = 1'b0, use_imm = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic [12:0] imm = '0;
  logic [31:0] result;
  logic        flag_n, flag_z, flag_v, flag_c, trap_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] e_res = '0;
  logic        e_n = 0, e_z = 0, e_v = 0, e_c = 0, e_trap = 0;

  always #2 clk = ~clk;

  tagged_addsub_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .sub_sel(sub_sel),
    .tag_mode(tag_mode), .trap_mode(trap_mode), .flags_en(flags_en),
    .use_imm(use_imm), .opa(opa), .opb(opb), .imm(imm), .result(result),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
    .trap_req(trap_req)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] oper2(input logic ui, input logic [31:0] b, input logic [12:0] im);
    if (!ui) return b;
    return 32'($signed(im));
  endfunction

  task automatic run_op(input logic v, input logic s, input logic t, input logic tr,
                        input logic fe, input logic ui, input logic [31:0] a,
                        input logic [31:0] b, input logic [12:0] im, input string req);
    logic [31:0] o2, r;
    logic n, z, ov, c, tagged_bad, trp;
    @(negedge clk);
    op_valid = v; sub_sel = s; tag_mode = t; trap_mode = tr;
    flags_en = fe; use_imm = ui; opa = a; opb = b; imm = im;
    o2 = oper2(ui, b, im);
    if (s) begin
      r  = a - o2;
      c  = (a < o2);
      ov = (a[31] != o2[31]) && (r[31] != a[31]);
    end else begin
      {c, r} = {1'b0, a} + {1'b0, o2};
      ov = (a[31] == o2[31]) && (r[31] != a[31]);
    end
    tagged_bad = t && ((a[1:0] != 2'b00) || (o2[1:0] != 2'b00));
    ov = ov || tagged_bad;
    n = r[31];
    z = (r == 32'd0);
    trp = v && t && tr && ov;
    e_trap = trp;
    if (v && !trp) begin
      e_res = r;
      if (fe) begin e_n = n; e_z = z; e_v = ov; e_c = c; end
    end
    @(posedge clk);
    #1;
    chk(s ? "R3" : "R2", "result", result, e_res);
    chk("R5", "flag_n", 32'(flag_n), 32'(e_n));
    chk("R5", "flag_z", 32'(flag_z), 32'(e_z));
    chk("R6", "flag_c", 32'(flag_c), 32'(e_c));
    chk(t ? "R8" : "R7", "flag_v", 32'(flag_v), 32'(e_v));
    chk("R10", "trap_req", 32'(trap_req), 32'(e_trap));
    if (req != "") chk(req, "scenario result", result, e_res);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset result", result, 32'd0);
    chk("R1", "reset flags", 32'({flag_n, flag_z, flag_v, flag_c, trap_req}), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "post-reset result", result, 32'd0);

    run_op(1, 0, 0, 0, 1, 0, 32'h7fff_ffff, 32'd4, 0, "R7");
    run_op(1, 0, 0, 0, 1, 0, 32'hffff_ffff, 32'd1, 0, "R6");
    run_op(1, 1, 0, 0, 1, 0, 32'd0, 32'd4, 0, "R6");
    run_op(1, 1, 0, 0, 1, 0, 32'h1234_5678, 32'h1234_5678, 0, "R5");
    run_op(1, 1, 0, 0, 1, 0, 32'h8000_0000, 32'd1, 0, "R7");
    run_op(1, 0, 0, 0, 1, 1, 32'd10000, 32'hdead_beef, 13'h1000, "R4");
    run_op(1, 1, 0, 0, 1, 1, 32'd0, 32'hdead_beef, 13'h0fff, "R4");
    run_op(1, 0, 1, 0, 1, 0, 32'd5, 32'd8, 0, "R8");
    run_op(1, 0, 1, 0, 1, 0, 32'd8, 32'd12, 0, "R8");
    run_op(1, 1, 1, 0, 1, 1, 32'd64, 32'd0, 13'h0002, "R8");
    run_op(1, 0, 0, 0, 0, 0, 32'hffff_ffff, 32'd1, 0, "R9");
    run_op(1, 0, 1, 1, 1, 0, 32'd100, 32'd7, 0, "R10");
    run_op(1, 0, 1, 1, 1, 0, 32'd100, 32'd8, 0, "R10");
    run_op(0, 1, 0, 0, 1, 0, 32'h5555_5555, 32'd3, 0, "R11");

    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = $urandom;
      if (($urandom % 4) == 0) a[1:0] = 2'b00;
      if (($urandom % 4) == 0) b[1:0] = 2'b00;
      run_op(($urandom % 8) != 0, 1'($urandom), 1'($urandom), 1'($urandom),
             ($urandom % 4) != 0, 1'($urandom), a, b, 13'($urandom), "");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule